// File: doc/BRIEF.md
# Battery Switchover Controller

This controller decides whether the internal supply rail of a chip is taken from the main supply or from a backup battery. It sees three asynchronous inputs: two comparator outputs ("main supply under 2.75 V" and "supervisory input under 1.2 V") and an external battery-control pin. It also sees a configuration field that picks the trigger and a pin-function field that enables the control pin. From these it drives a registered source-select output and a read-only status bit.

The move to battery is caused by one trigger, chosen by configuration. The external pin, when enabled, can also force the move at any time. The return to the main supply is stricter. Every enabled condition must hold at the same time, and must keep holding for a programmable number of clock cycles. Each transition sets a latched event flag. Software clears a flag by writing to it. The flags are gated by per-event enables and a global enable to form one shared interrupt.

Top module: `bsw_ctrl`

## Requirements
- R1: After reset the main supply is selected (`status_main`=1, `bat_sel`=0), both event flags are 0 and `irq` is 0.
- R2: With `trig_sel`=00, a rise on `main_low_a` selects the battery on the third clock edge after the change: two synchronizer stages, then the state register.
- R3: With `trig_sel`=01, a rise on `sup_low_a` selects the battery with the same three-edge latency, and `main_low_a` alone does not cause a switch.
- R4: When `trig_sel[1]`=1, no input causes a switch to battery. If the battery is selected when the bit is set, the main supply is selected at the next clock edge.
- R5: When `pin_func`=01, a falling edge on the synchronized `pin_a` selects the battery, with three-edge latency, under trigger setting 00 or 01. With any other `pin_func` value the pin is ignored.
- R6: The return to main needs `main_low_a` low on the synchronized path for `QUAL_CYCLES` consecutive cycles. The main supply is selected `QUAL_CYCLES`+2 edges after `main_low_a` falls.
- R7: The return also needs `sup_low_a` low when `trig_sel`=01, and `pin_a` high when the pin is enabled. All of these conditions must hold together for the whole window.
- R8: If any restore condition drops for a single cycle during the window, the count restarts from zero.
- R9: `status_main` is 1 exactly while the main supply is selected, and `bat_sel` is its complement. Both come from one state register.
- R10: `evt_flags[0]` is set by every switch to battery and `evt_flags[1]` by every return to main. A set flag holds until a cycle with `clr_we`=1 and the matching `clr_mask` bit set.
- R11: If a clear write and a new event for the same flag occur in the same cycle, the flag is set.
- R12: `irq` is registered and reflects `irq_gen_en` AND (any flag AND its `irq_evt_en` bit) one edge after the flags. It is 0 whenever `irq_gen_en` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_low_a | input | 1 | Asynchronous comparator: main supply under 2.75 V |
| sup_low_a | input | 1 | Asynchronous comparator: supervisory input under 1.2 V |
| pin_a | input | 1 | Asynchronous external battery-control pin |
| trig_sel | input | 2 | Trigger select: 00 main low, 01 supervisory low, 1x switchover off |
| pin_func | input | 2 | Pin function bits; 01 enables the control pin |
| clr_we | input | 1 | Flag clear write strobe |
| clr_mask | input | 2 | Flags to clear (bit0 switch, bit1 restore) |
| irq_gen_en | input | 1 | Global power-management interrupt enable |
| irq_evt_en | input | 2 | Per-flag interrupt enables |
| bat_sel | output | 1 | Source select, 1 = battery feeds the rail |
| status_main | output | 1 | Status bit, 1 = main supply selected |
| evt_flags | output | 2 | Latched flags: bit0 switched to battery, bit1 restored |
| irq | output | 1 | Shared power-management interrupt |

## Verification
The switch is tried with each trigger source: the main comparator, the supervisory comparator and a pin falling edge. Each is also tried in a configuration where it must be ignored, which shows that the trigger select chooses one source rather than OR-ing all of them. The return is tried with a clean window, a one-cycle glitch inside the window, and a held supervisory or pin condition. These show apart a counter that restarts, one that merely pauses, and a restore that checks only the main comparator. A clear and an event in the same cycle, and disabling the switch while on battery, probe flag priority and the override path.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic {SRC_MAIN = 1'b0, SRC_BATT = 1'b1} src_e;
  localparam logic [1:0] TRIG_MAIN = 2'b00;
  localparam logic [1:0] TRIG_SUP  = 2'b01;

  function automatic logic pin_ctl_en(input logic [1:0] f);
    return f == 2'b01;
  endfunction
endpackage

// File: rtl/bsw_sync.sv
module bsw_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk) begin
      if (rst) begin
        st1 <= RST_VAL[i];
        st2 <= RST_VAL[i];
      end else begin
        st1 <= d_a[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/bsw_qual.sv
module bsw_qual #(
  parameter int QUAL = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cond,
  output logic ok
);
  localparam int CW = (QUAL < 2) ? 1 : $clog2(QUAL);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || !cond) cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign ok = arm && cond && (cnt == LAST);

  // a dropped condition empties the window
  p_count_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (arm && !cond) |=> (cnt == '0));
endmodule

// File: rtl/bsw_flags.sv
module bsw_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         gen_en,
  input  logic [N-1:0] evt_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) flags[i] <= 1'b0;
    end

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(clr_we && clr_mask[i])) |=> flags[i]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gen_en && |(flags & evt_en);
  end

  p_irq_gated_r12: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> !irq);
endmodule

// File: rtl/bsw_ctrl.sv
module bsw_ctrl
  import bsw_pkg::*;
#(
  parameter int QUAL_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_low_a,
  input  logic       sup_low_a,
  input  logic       pin_a,
  input  logic [1:0] trig_sel,
  input  logic [1:0] pin_func,
  input  logic       clr_we,
  input  logic [1:0] clr_mask,
  input  logic       irq_gen_en,
  input  logic [1:0] irq_evt_en,
  output logic       bat_sel,
  output logic       status_main,
  output logic [1:0] evt_flags,
  output logic       irq
);
  localparam int NIN = 3;
  localparam logic [NIN-1:0] SYNC_RST = 3'b100;

  logic [NIN-1:0] s_vec;
  logic s_main_low, s_sup_low, s_pin, pin_d;
  logic dis, pin_en, pin_fall, trig_hit, restore_cond;
  logic on_batt, arm, qual_ok, go_batt, go_main;
  src_e src_q;

  bsw_sync #(.W(NIN), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_a({pin_a, sup_low_a, main_low_a}), .q(s_vec)
  );
  assign s_main_low = s_vec[0];
  assign s_sup_low  = s_vec[1];
  assign s_pin      = s_vec[2];

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b1;
    else     pin_d <= s_pin;
  end

  assign dis      = trig_sel[1];
  assign pin_en   = pin_ctl_en(pin_func);
  assign pin_fall = pin_d && !s_pin;
  assign trig_hit = (trig_sel == TRIG_MAIN && s_main_low) ||
                    (trig_sel == TRIG_SUP  && s_sup_low)  ||
                    (pin_en && pin_fall);
  assign restore_cond = !s_main_low &&
                        !(trig_sel == TRIG_SUP && s_sup_low) &&
                        !(pin_en && !s_pin);

  assign on_batt = (src_q == SRC_BATT);
  assign arm     = on_batt && !dis;

  bsw_qual #(.QUAL(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .arm(arm), .cond(restore_cond), .ok(qual_ok)
  );

  assign go_batt = !on_batt && !dis && trig_hit;
  assign go_main = on_batt && (dis || qual_ok);

  always_ff @(posedge clk) begin
    if (rst)          src_q <= SRC_MAIN;
    else if (go_batt) src_q <= SRC_BATT;
    else if (go_main) src_q <= SRC_MAIN;
  end

  assign bat_sel     = on_batt;
  assign status_main = !on_batt;

  bsw_flags #(.N(2)) u_flags (
    .clk(clk), .rst(rst), .set_evt({go_main, go_batt}), .clr_we(clr_we),
    .clr_mask(clr_mask), .gen_en(irq_gen_en), .evt_en(irq_evt_en),
    .flags(evt_flags), .irq(irq)
  );

  p_disable_main_r4: assert property (@(posedge clk) disable iff (rst)
    dis |=> !bat_sel);
  p_no_early_restore_r6: assert property (@(posedge clk) disable iff (rst)
    (bat_sel && !dis && !qual_ok) |=> bat_sel);
  p_switch_flagged_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_sel) |-> evt_flags[0]);
endmodule

// File: tb/bsw_ctrl_test.sv
module bsw_ctrl_test;
  localparam int PERIOD = 10;
  localparam int QUAL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_low_a = 1'b0, sup_low_a = 1'b0, pin_a = 1'b1;
  logic [1:0] trig_sel = 2'b00, pin_func = 2'b00, clr_mask = 2'b00, irq_evt_en = 2'b00;
  logic clr_we = 1'b0, irq_gen_en = 1'b0;
  logic bat_sel, status_main, irq;
  logic [1:0] evt_flags;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  bsw_ctrl #(.QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst(rst), .main_low_a(main_low_a), .sup_low_a(sup_low_a),
    .pin_a(pin_a), .trig_sel(trig_sel), .pin_func(pin_func), .clr_we(clr_we),
    .clr_mask(clr_mask), .irq_gen_en(irq_gen_en), .irq_evt_en(irq_evt_en),
    .bat_sel(bat_sel), .status_main(status_main), .evt_flags(evt_flags), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_mask = 2'b11;
    tick(1);
    clr_we = 1'b0; clr_mask = 2'b00;
  endtask

  task automatic t_reset();
    check("R1 status", {1'b0, status_main}, 2'b01);
    check("R1 bat_sel", {1'b0, bat_sel}, 2'b00);
    check("R1 flags", evt_flags, 2'b00);
    check("R1 irq", {1'b0, irq}, 2'b00);
  endtask

  task automatic t_main_trigger();
    main_low_a = 1'b1;
    tick(2);
    check("R2 not before third edge", {1'b0, status_main}, 2'b01);
    tick(1);
    check("R2 battery on third edge", {1'b0, status_main}, 2'b00);
    check("R9 bat_sel complement", {1'b0, bat_sel}, 2'b01);
    check("R10 switch flag", evt_flags, 2'b01);
  endtask

  task automatic t_restore();
    main_low_a = 1'b0;
    tick(QUAL + 1);
    check("R6 still battery in window", {1'b0, status_main}, 2'b00);
    tick(1);
    check("R6 main after window", {1'b0, status_main}, 2'b01);
    check("R10 both flags held", evt_flags, 2'b11);
  endtask

  task automatic t_irq();
    irq_gen_en = 1'b0; irq_evt_en = 2'b11;
    tick(2);
    check("R12 global off", {1'b0, irq}, 2'b00);
    irq_gen_en = 1'b1; irq_evt_en = 2'b10;
    tick(2);
    check("R12 restore enabled", {1'b0, irq}, 2'b01);
    clr_we = 1'b1; clr_mask = 2'b10;
    tick(1);
    clr_we = 1'b0; clr_mask = 2'b00;
    check("R10 masked clear", evt_flags, 2'b01);
    tick(1);
    check("R12 cleared flag drops irq", {1'b0, irq}, 2'b00);
    irq_evt_en = 2'b01;
    tick(2);
    check("R12 switch enabled", {1'b0, irq}, 2'b01);
    irq_gen_en = 1'b0;
    tick(2);
    check("R12 global off again", {1'b0, irq}, 2'b00);
    clear_all();
    check("R10 clear all", evt_flags, 2'b00);
  endtask

  task automatic t_collision();
    main_low_a = 1'b1;
    tick(2);
    clr_we = 1'b1; clr_mask = 2'b01;
    tick(1);
    clr_we = 1'b0; clr_mask = 2'b00;
    check("R11 set beats clear", evt_flags, 2'b01);
    check("R11 switched", {1'b0, status_main}, 2'b00);
    main_low_a = 1'b0;
    tick(QUAL + 2);
    clear_all();
  endtask

  task automatic t_glitch();
    main_low_a = 1'b1;
    tick(3);
    main_low_a = 1'b0;
    tick(8);
    main_low_a = 1'b1;
    tick(1);
    main_low_a = 1'b0;
    tick(QUAL + 1);
    check("R8 restart keeps battery", {1'b0, status_main}, 2'b00);
    tick(1);
    check("R8 main after full window", {1'b0, status_main}, 2'b01);
    clear_all();
  endtask

  task automatic t_sup();
    trig_sel = 2'b01;
    main_low_a = 1'b1;
    tick(6);
    check("R3 main comparator ignored", {1'b0, status_main}, 2'b01);
    main_low_a = 1'b0; sup_low_a = 1'b1;
    tick(3);
    check("R3 supervisory switch", {1'b0, status_main}, 2'b00);
    tick(30);
    check("R7 supervisory low blocks restore", {1'b0, status_main}, 2'b00);
    sup_low_a = 1'b0;
    tick(QUAL + 1);
    check("R7 window after supervisory ok", {1'b0, status_main}, 2'b00);
    tick(1);
    check("R7 restored", {1'b0, status_main}, 2'b01);
    trig_sel = 2'b00;
    clear_all();
  endtask

  task automatic t_pin();
    pin_func = 2'b01;
    pin_a = 1'b0;
    tick(2);
    check("R5 pin not before third edge", {1'b0, status_main}, 2'b01);
    tick(1);
    check("R5 pin fall switch", {1'b0, status_main}, 2'b00);
    tick(30);
    check("R7 pin low blocks restore", {1'b0, status_main}, 2'b00);
    pin_a = 1'b1;
    tick(QUAL + 1);
    check("R7 window after pin high", {1'b0, status_main}, 2'b00);
    tick(1);
    check("R7 pin restore", {1'b0, status_main}, 2'b01);
    pin_func = 2'b00;
    pin_a = 1'b0;
    tick(6);
    check("R5 disabled pin ignored", {1'b0, status_main}, 2'b01);
    pin_a = 1'b1;
    tick(3);
    clear_all();
    check("R5 no flag from disabled pin", evt_flags, 2'b00);
  endtask

  task automatic t_disable();
    trig_sel = 2'b10; pin_func = 2'b01;
    main_low_a = 1'b1; sup_low_a = 1'b1; pin_a = 1'b0;
    tick(8);
    check("R4 disabled stays main", {1'b0, status_main}, 2'b01);
    main_low_a = 1'b0; sup_low_a = 1'b0; pin_a = 1'b1; pin_func = 2'b00;
    tick(4);
    trig_sel = 2'b00; main_low_a = 1'b1;
    tick(3);
    check("R4 on battery before disable", {1'b0, status_main}, 2'b00);
    trig_sel = 2'b11;
    tick(1);
    check("R4 disable forces main next edge", {1'b0, status_main}, 2'b01);
    main_low_a = 1'b0;
    tick(4);
    trig_sel = 2'b00;
    tick(2);
    check("R4 stays main after enable", {1'b0, status_main}, 2'b01);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_main_trigger();
    t_restore();
    t_irq();
    t_collision();
    t_glitch();
    t_sup();
    t_pin();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule